// File: doc/BRIEF.md
# Programmable Clock Synthesizer Divider

This block turns the system clock into a slower clock for a sensor interface. A single 32-bit configuration word sets the divider. The word carries an enable flag and three 8-bit counts: one for the high phase, one for the low phase and one for a hold window. Software writes the word through a one-cycle write strobe. The block keeps it in a shadow register and applies it to the running counters only at the end of an output period. A change of setting therefore never shortens or stretches a phase already in progress.

The divided clock appears as a level output. A one-cycle strobe marks the first high cycle of each period, so logic in the system clock domain can use it directly as a clock enable. A hold window opens together with each rising edge and stays open for a programmed number of cycles. It gives downstream logic a guaranteed settling interval after each edge.

The supported ratios run from 2:1 to 512:1. A ratio setting K (0 to 510) maps to a high count of K>>1 and a low count of (K+1)>>1, which gives a period of K+2 cycles.

Top module: `clk_synth_div`

## Requirements
- R1: While reset is asserted, and afterwards until an enabled word is applied, `div_clk_o`, `period_stb_o` and `hold_o` are all low.
- R2: The configuration word decodes as follows: low count in bits 7:0, high count in bits 15:8, hold count in bits 23:16, enable in bit 24. Bits 31:25 have no effect.
- R3: When enabled, `div_clk_o` is high for (high count + 1) cycles and then low for (low count + 1) cycles. The period is therefore between 2 and 512 cycles.
- R4: For a ratio setting K, a word with high = K>>1, low = (K+1)>>1 and hold = K>>1 gives a period of exactly K+2 cycles. This holds at K=0, at K=510 and for odd K.
- R5: `period_stb_o` is high for exactly one cycle per period, namely the first cycle in which `div_clk_o` is high.
- R6: `hold_o` goes high in the strobe cycle and stays high for (hold count + 1) cycles. It restarts at every rising edge of `div_clk_o`.
- R7: Writing a word with the enable bit clear lets the current period finish. After that, all three outputs stay low. A later enable starts from a fresh full high phase.
- R8: A word written while the divider runs takes effect only at the end of the current period. The period in progress keeps its old high and low lengths.
- R9: When the divider is idle, a word written in the cycle ending at edge E0 makes `div_clk_o` and `period_stb_o` go high in the cycle after edge E1.
- R10: If several words are written before the next period boundary, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word |
| div_clk_o | output | 1 | Divided clock level |
| period_stb_o | output | 1 | One-cycle strobe on each rising edge of the divided clock |
| hold_o | output | 1 | Hold window after each rising edge |

## Verification
A phase counter in the wrong state shows up within one period as a wrong count of high or low cycles. A lost or early configuration load shows up in the first period after the write: either the period in progress is cut short, or the new lengths never arrive. Hold-counter faults show up in the very next period as a wrong number of `hold_o` cycles measured from the strobe. A wrongly cleared run flag shows up either as activity after a disable or as a missing first strobe two cycles after an enabling write.

// File: rtl/clk_synth_pkg.sv
package clk_synth_pkg;
  localparam int FIELD_W  = 8;
  localparam int WORD_W   = 32;
  localparam int LO_LSB   = 0;
  localparam int HI_LSB   = LO_LSB + FIELD_W;
  localparam int HOLD_LSB = HI_LSB + FIELD_W;
  localparam int EN_BIT   = HOLD_LSB + FIELD_W;

  typedef logic [FIELD_W-1:0] cnt_t;

  typedef struct packed {
    logic en;
    cnt_t hold;
    cnt_t hi;
    cnt_t lo;
  } synth_cfg_t;

  function automatic synth_cfg_t unpack_cfg(input logic [EN_BIT:0] w);
    synth_cfg_t c;
    c.lo   = w[LO_LSB   +: FIELD_W];
    c.hi   = w[HI_LSB   +: FIELD_W];
    c.hold = w[HOLD_LSB +: FIELD_W];
    c.en   = w[EN_BIT];
    return c;
  endfunction
endpackage

// File: rtl/clk_synth_cfg.sv
module clk_synth_cfg
  import clk_synth_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              boundary_i,
  output logic              apply_o,
  output logic              next_en_o,
  output synth_cfg_t        act_o
);
  synth_cfg_t shd_q, act_q;
  logic       pend_q;
  logic       unused_hi_bits;

  assign unused_hi_bits = ^wdata_i[WORD_W-1:EN_BIT+1];
  assign apply_o   = pend_q & boundary_i;
  assign next_en_o = shd_q.en;
  assign act_o     = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (we_i) shd_q <= unpack_cfg(wdata_i[EN_BIT:0]);
      if (we_i)         pend_q <= 1'b1;
      else if (apply_o) pend_q <= 1'b0;
      if (apply_o) act_q <= shd_q;
    end
  end

  // active setting only moves at a period boundary
  p_cfg_only_at_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(act_q));
endmodule

// File: rtl/clk_synth_phase.sv
module clk_synth_phase
  import clk_synth_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t lo_i,
  input  cnt_t hi_i,
  input  logic apply_i,
  input  logic next_en_i,
  output logic high_o,
  output logic boundary_o,
  output logic rise_o,
  output logic stb_o
);
  cnt_t cnt_q;
  logic run_q, high_q;
  logic end_lo, end_hi;

  assign end_lo     = run_q & ~high_q & (cnt_q == lo_i);
  assign end_hi     = run_q &  high_q & (cnt_q == hi_i);
  assign boundary_o = ~run_q | end_lo;
  assign rise_o     = apply_i ? next_en_i : end_lo;
  assign stb_o      = run_q & high_q & (cnt_q == '0);
  assign high_o     = high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      high_q <= 1'b0;
      cnt_q  <= '0;
    end else if (apply_i) begin
      run_q  <= next_en_i;
      high_q <= next_en_i;
      cnt_q  <= '0;
    end else if (end_lo) begin
      high_q <= 1'b1;
      cnt_q  <= '0;
    end else if (end_hi) begin
      high_q <= 1'b0;
      cnt_q  <= '0;
    end else if (run_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_high_phase_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && high_q && cnt_q != hi_i) |=> (high_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/clk_synth_hold.sv
module clk_synth_hold
  import clk_synth_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t len_i,
  input  logic rise_i,
  input  logic stop_i,
  output logic hold_o
);
  cnt_t cnt_q;
  logic act_q;

  assign hold_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (rise_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop_i) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (cnt_q == len_i) act_q <= 1'b0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  p_hold_opens_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> hold_o);
endmodule

// File: rtl/clk_synth_div.sv
module clk_synth_div
  import clk_synth_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic              div_clk_o,
  output logic              period_stb_o,
  output logic              hold_o
);
  synth_cfg_t act;
  logic apply, next_en, boundary, rise;

  clk_synth_cfg i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wdata_i    (cfg_wdata_i),
    .boundary_i (boundary),
    .apply_o    (apply),
    .next_en_o  (next_en),
    .act_o      (act)
  );

  clk_synth_phase i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lo_i       (act.lo),
    .hi_i       (act.hi),
    .apply_i    (apply),
    .next_en_i  (next_en),
    .high_o     (div_clk_o),
    .boundary_o (boundary),
    .rise_o     (rise),
    .stb_o      (period_stb_o)
  );

  clk_synth_hold i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .len_i  (act.hold),
    .rise_i (rise),
    .stop_i (apply & ~next_en),
    .hold_o (hold_o)
  );

  p_stb_marks_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_stb_o == $rose(div_clk_o));
endmodule

// File: tb/test_clk_synth_div.sv
`timescale 1ns/1ps
module test_clk_synth_div;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0;
  logic div, stb, hold;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_synth_div i_clk_synth_div (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .div_clk_o(div), .period_stb_o(stb), .hold_o(hold));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(int lo, int hi, int hd, bit en);
    return {7'b0, en, hd[7:0], hi[7:0], lo[7:0]};
  endfunction

  function automatic logic [31:0] kword(int k);
    return word((k + 1) >> 1, k >> 1, k >> 1, 1'b1);
  endfunction

  task automatic write_cfg(logic [31:0] w);
    we = 1'b1; wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_stb();
    int g = 0;
    while (!stb && g < 3000) begin @(negedge clk); g++; end
  endtask

  task automatic measure(int wr_at, logic [31:0] wr_word, output int hi, output int lo, output int hd);
    int i = 0;
    wait_stb();
    hi = 0; lo = 0; hd = 0;
    do begin
      if (div) hi++; else lo++;
      if (hold) hd++;
      we = (i == wr_at);
      if (i == wr_at) wdata = wr_word;
      @(negedge clk);
      i++;
    end while (!stb && i < 3000);
    we = 1'b0;
  endtask

  task automatic skip_measure(output int hi, output int lo, output int hd);
    wait_stb();
    @(negedge clk);
    measure(-1, '0, hi, lo, hd);
  endtask

  task automatic t_reset();
    int act = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 5) rst_n = 1'b1;
      act += div + stb + hold;
    end
    chk("R1 outputs quiet after reset", act, 0);
  endtask

  task automatic t_start();
    int hi, lo, hd;
    write_cfg(word(2, 1, 0, 1'b1));
    chk("R9 div low one cycle after write", int'(div), 0);
    @(negedge clk);
    chk("R9 div high two cycles after write", int'(div), 1);
    chk("R9 strobe with first edge", int'(stb), 1);
    chk("R6 hold opens with strobe", int'(hold), 1);
    measure(-1, '0, hi, lo, hd);
    chk("R3 high len lo2/hi1", hi, 2);
    chk("R3 low len lo2/hi1", lo, 3);
    chk("R6 hold len 0", hd, 1);
  endtask

  task automatic t_fields();
    int hi, lo, hd;
    int l[3] = '{3, 0, 7};
    int h[3] = '{5, 0, 2};
    int d[3] = '{2, 0, 9};
    for (int n = 0; n < 3; n++) begin
      // bits 31:25 set on the last word (R2)
      write_cfg(word(l[n], h[n], d[n], 1'b1) | (n == 2 ? 32'hFE00_0000 : 32'h0));
      skip_measure(hi, lo, hd);
      chk("R3 high phase", hi, h[n] + 1);
      chk("R3 low phase", lo, l[n] + 1);
      chk("R2 field decode hold", hd, d[n] + 1);
      chk("R5 single strobe per period", hi + lo, l[n] + h[n] + 2);
    end
  endtask

  task automatic t_ratio();
    int hi, lo, hd;
    int ks[4] = '{0, 1, 7, 510};
    for (int n = 0; n < 4; n++) begin
      write_cfg(kword(ks[n]));
      skip_measure(hi, lo, hd);
      chk("R4 period K+2", hi + lo, ks[n] + 2);
      chk("R4 high from K", hi, (ks[n] >> 1) + 1);
      chk("R4 hold from K", hd, (ks[n] >> 1) + 1);
    end
  endtask

  task automatic t_midchange();
    int hi, lo, hd;
    write_cfg(word(9, 9, 0, 1'b1));
    skip_measure(hi, lo, hd);
    measure(3, word(1, 1, 0, 1'b1), hi, lo, hd);
    chk("R8 current period keeps high", hi, 10);
    chk("R8 current period keeps low", lo, 10);
    measure(-1, '0, hi, lo, hd);
    chk("R8 new high after boundary", hi, 2);
    chk("R8 new low after boundary", lo, 2);
  endtask

  task automatic t_last_wins();
    int hi, lo, hd;
    we = 1'b1; wdata = word(6, 6, 0, 1'b1);
    @(negedge clk);
    wdata = word(2, 4, 1, 1'b1);
    @(negedge clk);
    we = 1'b0;
    skip_measure(hi, lo, hd);
    chk("R10 last write high", hi, 5);
    chk("R10 last write low", lo, 3);
    chk("R10 last write hold", hd, 2);
  endtask

  task automatic t_disable();
    int hi, lo, hd, cnt;
    write_cfg(word(4, 4, 1, 1'b1));
    wait_stb();
    @(negedge clk);
    wait_stb();
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      cnt += div;
      we = (i == 2); wdata = '0;
      @(negedge clk);
    end
    we = 1'b0;
    chk("R7 last period completes", cnt, 5);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      cnt += div + stb + hold;
      @(negedge clk);
    end
    chk("R7 quiet when disabled", cnt, 0);
    write_cfg(word(4, 4, 1, 1'b1));
    measure(-1, '0, hi, lo, hd);
    chk("R7 restart full high", hi, 5);
    chk("R7 restart full low", lo, 5);
  endtask

  initial begin
    t_reset();
    t_start();
    t_fields();
    t_ratio();
    t_midchange();
    t_last_wins();
    t_disable();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule